// File: doc/BRIEF.md
# Timed-Event Record Stream Decoder

The decoder consumes a byte stream of packed timed-output records, one byte per valid/ready handshake, and turns each record into a single output-event command. A record starts with a length byte that counts every byte of the record. A fixed header follows with a channel number, a timestamp and a sub-address. The payload is one to sixteen 32-bit data words. Multi-byte fields arrive least significant byte first.

Once the last payload byte is in, the decoder presents the channel, timestamp, sub-address and a 512-bit data bus on a command port with back-pressure. Data words that the record does not carry read as zero. A length byte of zero marks the end of the stream and produces a done pulse. An impossible length byte produces an error pulse, and the decoder then discards bytes until it sees a zero byte.

Top module: `evrec_decoder`

## Requirements
- R1: The first byte of a record is its total length L in bytes, header and payload together. Exactly one command is issued per valid record, and cmd_valid_o rises only in the cycle after the record's final byte (byte L-1) is accepted.
- R2: Record bytes 1..3 form cmd_chan_o, least significant byte first: byte 1 goes to bits [7:0].
- R3: Record bytes 4..11 form cmd_ts_o, least significant byte first: byte 4 goes to bits [7:0] and byte 11 goes to bits [63:56].
- R4: Record byte 12 is the sub-address on cmd_addr_o. The header is therefore 13 bytes long.
- R5: Payload byte j of word k (record byte 13+4k+j) appears at cmd_data_o[32k+8j +: 8].
- R6: For a record with N words, cmd_data_o bits from 32N up to 511 are zero, even when an earlier record set them.
- R7: A length byte below 17, above 77, or with (L-13) not a multiple of 4 raises err_o for exactly one cycle. Later bytes are then dropped and issue no command, including bytes that would be valid lengths. A zero byte ends the discard: it raises done_o for one cycle and returns the decoder to waiting for a length byte.
- R8: A zero length byte received while waiting for a length raises done_o for one cycle, issues no command and leaves err_o low.
- R9: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high, all command fields stay stable and in_ready_o is low. The cycle after cmd_ready_i is seen high, cmd_valid_o is low and in_ready_o is high.
- R10: Reset (rst_ni low) returns the decoder to waiting for a length byte. It clears every command field, cmd_valid_o, err_o and done_o, and it abandons any partly received record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input stream byte |
| in_ready_o | output | 1 | Decoder can take a byte |
| cmd_valid_o | output | 1 | Command available |
| cmd_ready_i | input | 1 | Downstream takes the command |
| cmd_chan_o | output | 24 | Event channel |
| cmd_ts_o | output | 64 | Event timestamp |
| cmd_addr_o | output | 8 | Event sub-address |
| cmd_data_o | output | 512 | Zero-extended event data |
| err_o | output | 1 | One-cycle pulse on a bad length byte |
| done_o | output | 1 | One-cycle pulse on an end-of-stream byte |

## Verification
The bench builds the decoder with its default parameters: 24-bit channel, 64-bit timestamp, 8-bit address and sixteen 32-bit words. At these values every one of the 256 possible length bytes can be swept, each valid length with a full record and each invalid length with a discard and resync sequence. A descending sweep of word counts after a full 16-word record exposes any payload lane that fails to clear. Variable back-pressure holds and a reset in the middle of a record cover the handshake and recovery paths.

// File: rtl/evrec_pkg.sv
package evrec_pkg;
  typedef enum logic [1:0] {
    ST_LEN  = 2'd0,
    ST_BODY = 2'd1,
    ST_CMD  = 2'd2,
    ST_SKIP = 2'd3
  } evrec_state_e;
endpackage

// File: rtl/evrec_len_check.sv
module evrec_len_check #(
  parameter int HDR_B  = 13,
  parameter int WORD_B = 4,
  parameter int MAX_WORDS = 16
) (
  input  logic [7:0] len_i,
  output logic       zero_o,
  output logic       ok_o
);
  localparam int MIN_LEN = HDR_B + WORD_B;
  localparam int MAX_LEN = HDR_B + MAX_WORDS * WORD_B;

  logic [7:0] body;

  always_comb begin
    body   = len_i - 8'(HDR_B);
    zero_o = (len_i == 8'd0);
    ok_o   = (len_i >= 8'(MIN_LEN)) && (len_i <= 8'(MAX_LEN)) &&
             ((body % 8'(WORD_B)) == 8'd0);
  end
endmodule

// File: rtl/evrec_fsm.sv
module evrec_fsm
  import evrec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       len_zero_i,
  input  logic       len_ok_i,
  input  logic       cmd_ready_i,
  output logic       in_ready_o,
  output logic       cmd_valid_o,
  output logic       err_o,
  output logic       done_o,
  output logic       wr_o,
  output logic       clr_o,
  output logic [7:0] idx_o
);
  evrec_state_e state_q;
  logic [7:0]   cnt_q;
  logic [7:0]   len_q;
  logic         err_q;
  logic         done_q;
  logic         acc;

  always_comb begin
    in_ready_o  = (state_q != ST_CMD);
    cmd_valid_o = (state_q == ST_CMD);
    acc         = in_valid_i && in_ready_o;
    wr_o        = acc && (state_q == ST_BODY);
    clr_o       = acc && (state_q == ST_LEN) && len_ok_i;
    idx_o       = cnt_q;
    err_o       = err_q;
    done_o      = done_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LEN;
      cnt_q   <= '0;
      len_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_LEN: if (acc) begin
          if (len_zero_i) begin
            done_q <= 1'b1;
          end else if (len_ok_i) begin
            len_q   <= in_data_i;
            cnt_q   <= 8'd1;
            state_q <= ST_BODY;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_SKIP;
          end
        end
        ST_BODY: if (acc) begin
          cnt_q <= cnt_q + 8'd1;
          if (cnt_q == len_q - 8'd1) state_q <= ST_CMD;
        end
        ST_CMD: if (cmd_ready_i) state_q <= ST_LEN;
        ST_SKIP: if (acc && (in_data_i == 8'd0)) begin
          done_q  <= 1'b1;
          state_q <= ST_LEN;
        end
        default: state_q <= ST_LEN;
      endcase
    end
  end
endmodule

// File: rtl/evrec_byte_lane.sv
module evrec_byte_lane #(
  parameter int POS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       clr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] byte_i,
  output logic [7:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          q_o <= '0;
    else if (clr_i)                       q_o <= '0;
    else if (wr_i && idx_i == 8'(POS))    q_o <= byte_i;
  end
endmodule

// File: rtl/evrec_assembler.sv
module evrec_assembler #(
  parameter int CHAN_B = 3,
  parameter int TS_B   = 8,
  parameter int ADDR_B = 1,
  parameter int DATA_B = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  clr_i,
  input  logic [7:0]            idx_i,
  input  logic [7:0]            byte_i,
  output logic [CHAN_B*8-1:0]   chan_o,
  output logic [TS_B*8-1:0]     ts_o,
  output logic [ADDR_B*8-1:0]   addr_o,
  output logic [DATA_B*8-1:0]   data_o
);
  localparam int TOT_B   = CHAN_B + TS_B + ADDR_B + DATA_B;
  localparam int TS_LO   = CHAN_B * 8;
  localparam int ADDR_LO = (CHAN_B + TS_B) * 8;
  localparam int DATA_LO = (CHAN_B + TS_B + ADDR_B) * 8;

  logic [TOT_B*8-1:0] flat;

  // lane i holds record byte i+1 (byte 0 is the length)
  for (genvar i = 0; i < TOT_B; i++) begin : g_lane
    evrec_byte_lane #(.POS(i + 1)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_i),
      .clr_i  (clr_i),
      .idx_i  (idx_i),
      .byte_i (byte_i),
      .q_o    (flat[i*8 +: 8])
    );
  end

  assign chan_o = flat[TS_LO-1:0];
  assign ts_o   = flat[ADDR_LO-1:TS_LO];
  assign addr_o = flat[DATA_LO-1:ADDR_LO];
  assign data_o = flat[TOT_B*8-1:DATA_LO];
endmodule

// File: rtl/evrec_decoder.sv
module evrec_decoder #(
  parameter int CHAN_W    = 24,
  parameter int TS_W      = 64,
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 16,
  localparam int DATA_W   = WORD_W * MAX_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CHAN_W-1:0] cmd_chan_o,
  output logic [TS_W-1:0]   cmd_ts_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              err_o,
  output logic              done_o
);
  localparam int CHAN_B = CHAN_W / 8;
  localparam int TS_B   = TS_W / 8;
  localparam int ADDR_B = ADDR_W / 8;
  localparam int WORD_B = WORD_W / 8;
  localparam int DATA_B = DATA_W / 8;
  localparam int HDR_B  = 1 + CHAN_B + TS_B + ADDR_B;

  logic       len_zero, len_ok, wr, clr;
  logic [7:0] idx;

  evrec_len_check #(.HDR_B(HDR_B), .WORD_B(WORD_B), .MAX_WORDS(MAX_WORDS)) u_len (
    .len_i  (in_data_i),
    .zero_o (len_zero),
    .ok_o   (len_ok)
  );

  evrec_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .len_zero_i  (len_zero),
    .len_ok_i    (len_ok),
    .cmd_ready_i (cmd_ready_i),
    .in_ready_o  (in_ready_o),
    .cmd_valid_o (cmd_valid_o),
    .err_o       (err_o),
    .done_o      (done_o),
    .wr_o        (wr),
    .clr_o       (clr),
    .idx_o       (idx)
  );

  evrec_assembler #(.CHAN_B(CHAN_B), .TS_B(TS_B), .ADDR_B(ADDR_B), .DATA_B(DATA_B)) u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .clr_i  (clr),
    .idx_i  (idx),
    .byte_i (in_data_i),
    .chan_o (cmd_chan_o),
    .ts_o   (cmd_ts_o),
    .addr_o (cmd_addr_o),
    .data_o (cmd_data_o)
  );
endmodule

// File: rtl/evrec_checker.sv
module evrec_checker #(
  parameter int CHAN_W = 24,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [CHAN_W-1:0] cmd_chan_o,
  input logic [TS_W-1:0]   cmd_ts_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic              err_o,
  input logic              done_o
);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_chan_o) &&
      $stable(cmd_ts_o) && $stable(cmd_addr_o) && $stable(cmd_data_o));

  p_no_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !in_ready_o);

  p_err_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o && !cmd_valid_o);

  p_done_no_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o && !err_o);

  p_cmd_on_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(in_valid_i && in_ready_o));
endmodule

bind evrec_decoder evrec_checker #(
  .CHAN_W(CHAN_W), .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/evrec_decoder_tb_top.sv
`timescale 1ns/1ps
module evrec_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_ready, cmd_valid, err, done;
  logic         cmd_ready = 1'b0;
  logic [23:0]  chan;
  logic [63:0]  ts;
  logic [7:0]   addr;
  logic [511:0] data;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  evrec_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_chan_o(chan), .cmd_ts_o(ts), .cmd_addr_o(addr), .cmd_data_o(data),
    .err_o(err), .done_o(done)
  );

  task automatic chk(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [511:0] word_mask(int nw);
    logic [511:0] m = '0;
    for (int k = 0; k < nw; k++) m[32*k +: 32] = 32'hFFFF_FFFF;
    return m;
  endfunction

  task automatic run_record(int nw, logic [23:0] ch, logic [63:0] t, logic [7:0] ad,
                            logic [511:0] dat, int hold);
    int len = 13 + 4 * nw;
    logic [511:0] m = word_mask(nw);
    send_byte(8'(len));
    chk(!err && !done, "R7 valid length no error", {err, done}, 0);
    for (int i = 0; i < 3; i++) send_byte(ch[8*i +: 8]);
    for (int i = 0; i < 8; i++) send_byte(t[8*i +: 8]);
    send_byte(ad);
    for (int i = 0; i < 4 * nw; i++) begin
      if (i == 4 * nw - 1) chk(!cmd_valid, "R1 no cmd before last byte", cmd_valid, 0);
      send_byte(dat[8*i +: 8]);
    end
    chk(cmd_valid, "R1 cmd after last byte", cmd_valid, 1);
    chk(chan == ch, "R2 channel", chan, ch);
    chk(ts == t, "R3 timestamp", ts, t);
    chk(addr == ad, "R4 address", addr, ad);
    chk((data & m) == (dat & m), "R5 payload", data & m, dat & m);
    chk((data & ~m) == '0, "R6 zero extension", data & ~m, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(cmd_valid && !in_ready && chan == ch && ts == t && addr == ad &&
          (data & m) == (dat & m), "R9 hold", {cmd_valid, in_ready}, 2'b10);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(!cmd_valid && in_ready, "R9 release", {cmd_valid, in_ready}, 2'b01);
  endtask

  function automatic logic [511:0] pattern(int seed);
    logic [511:0] d;
    for (int k = 0; k < 16; k++) d[32*k +: 32] = {8'(seed), 8'(k), 16'hA5C3 ^ 16'(k * 7)};
    return d;
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && in_ready && !err && !done && chan == 0 && ts == 0 &&
        addr == 0 && data == 0, "R10 reset state", {cmd_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 end marker
    send_byte(8'd0);
    chk(done && !err && !cmd_valid, "R8 done on zero", {done, err, cmd_valid}, 3'b100);
    @(negedge clk);
    chk(!done, "R8 done single pulse", done, 0);

    // R6 descending word counts after a full record
    run_record(16, 24'hFFFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, {512{1'b1}}, 0);
    for (int n = 16; n >= 1; n--)
      run_record(n, 24'(n * 24'h010203), {32'(n), 32'hDEAD_0000 + 32'(n)},
                 8'(n * 13), pattern(n), n % 4);

    // R7 / R1 sweep over every length byte
    for (int L = 1; L < 256; L++) begin
      if (L >= 17 && L <= 77 && ((L - 13) % 4) == 0) begin
        run_record((L - 13) / 4, 24'(L * 24'h0A0B07), {32'(L) ^ 32'h1234_5678, 32'(L * 3)},
                   8'(L), pattern(L), L % 3);
      end else begin
        send_byte(8'(L));
        chk(err && !done, "R7 error on bad length", {err, done}, 2'b10);
        send_byte(8'd17);
        chk(!err && !cmd_valid && !done, "R7 valid length dropped in discard",
            {err, cmd_valid, done}, 0);
        send_byte(8'hFF);
        chk(!cmd_valid && in_ready, "R7 bytes dropped", cmd_valid, 0);
        send_byte(8'd0);
        chk(done && !err && !cmd_valid, "R7 resync on zero", {done, err}, 2'b10);
      end
    end

    // R10 reset in the middle of a record
    send_byte(8'd21);
    for (int i = 0; i < 9; i++) send_byte(8'h5A);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!cmd_valid && in_ready && chan == 0 && ts == 0 && addr == 0 && data == 0,
        "R10 mid-record reset", chan, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_record(2, 24'hC0FFEE, 64'h0123_4567_89AB_CDEF, 8'h3C, pattern(99), 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule